// File: doc/BRIEF.md
# Timer Input Capture Unit

This block records the time at which something happens on an input pin. It watches one pin and looks for a selected kind of event. When that event occurs, it copies the value of one of two free-running 16-bit timers into a capture register. The capture register is split into a low byte and a high byte. The timers are built elsewhere and arrive on this block as input buses. A select bit picks which of the two timers is the time base.

Each capture sets a sticky interrupt flag. The flag is driven out on `irq_o` and stays set until the host clears it. The host reaches the capture bytes, the control register and the flag through a plain byte-wide register port. Writes take effect on a single-cycle write strobe, and reads are combinational on the address.

The pin passes through a synchronizer chain before edge detection. When the pin is configured as an output, the block watches the value being driven instead of the pad. A write to the output latch that makes a qualifying edge therefore causes a capture. The register port is a plain control interface and has no back-pressure: every strobe is accepted in the cycle it is given.

Top module: `tcap_top`

## Requirements
- R1: After reset, both capture bytes, the control register and the flag read 0, and `irq_o` is 0.
- R2: With mode code 4'b0100 (control bits 3:0), each falling edge of the observed pin captures. A rising edge does not capture.
- R3: With mode code 4'b0101, each rising edge captures. A falling edge does not capture.
- R4: With mode code 4'b0110, every fourth rising edge after the control register was last written captures. The three rising edges before it do not capture.
- R5: With mode code 4'b0111, every sixteenth rising edge after the control register was last written captures. The fifteen rising edges before it do not capture.
- R6: Any other mode code disables capture. Pin edges then leave the capture register and the flag unchanged.
- R7: Control bit 4 selects the time base: 0 selects `tmr_a_i` and 1 selects `tmr_b_i`. The captured value is the selected timer's value in the cycle the synchronized edge is detected.
- R8: A capture sets the flag (address 3, bit 0). The flag stays set until the host writes bit 0 of address 3 as 0. `irq_o` always equals the flag.
- R9: A new capture overwrites the capture register even if the earlier value was never read.
- R10: When `pin_oe_i` is 1, the observed pin is `pin_dout_i` and the pad `pin_i` is ignored. An edge produced on `pin_dout_i` captures like a pad edge.
- R11: If a host write clearing the flag lands in the same cycle as a capture, the flag ends up set.
- R12: Address 0 reads and writes capture bits 7:0. Address 1 reads and writes capture bits 15:8. Address 2 holds the select bit and the mode in bits 4:0, and its bits 7:5 read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_i | input | 1 | Pad level, asynchronous to the clock |
| pin_oe_i | input | 1 | 1 when the pin is configured as an output |
| pin_dout_i | input | 1 | Output latch value driven onto the pin |
| tmr_a_i | input | 16 | Timer A value |
| tmr_b_i | input | 16 | Timer B value |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Register write data |
| reg_rdata_o | output | 8 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Capture interrupt flag |

## Verification
The assertions assume that both timer buses change only on the system clock. They also assume the observed pin is low when reset is released, so that no spurious edge is seen as the synchronizer fills. The stimulus follows both assumptions: the timers are held constant around every edge, the pin starts low, and each pin level is held for four clock cycles so that every level change passes through the synchronizer before the next one.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
  localparam int TMR_W  = 16;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [3:0] {
    MODE_FALL   = 4'b0100,
    MODE_RISE   = 4'b0101,
    MODE_RISE4  = 4'b0110,
    MODE_RISE16 = 4'b0111
  } cap_mode_e;

  localparam logic [ADDR_W-1:0] A_CAP_LO = 2'd0;
  localparam logic [ADDR_W-1:0] A_CAP_HI = 2'd1;
  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd2;
  localparam logic [ADDR_W-1:0] A_FLAG   = 2'd3;

  typedef struct packed {
    logic       tsel;
    logic [3:0] mode;
  } cap_ctrl_t;
endpackage

// File: rtl/tcap_sync_edge.sv
module tcap_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain_q;
  logic              last_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= din;
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], din};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain_q[STAGES-1];

  assign rise = chain_q[STAGES-1] & ~last_q;
  assign fall = ~chain_q[STAGES-1] & last_q;
endmodule

// File: rtl/tcap_event_sel.sv
module tcap_event_sel
  import tcap_pkg::*;
#(
  parameter int PRE_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rise,
  input  logic       fall,
  input  logic [3:0] mode,
  input  logic       mode_wr,
  output logic       cap_ev
);
  localparam logic [PRE_W-1:0] LIM4  = PRE_W'(3);
  localparam logic [PRE_W-1:0] LIM16 = PRE_W'(15);

  logic [PRE_W-1:0] cnt_q;
  logic             prescaled;
  logic [PRE_W-1:0] lim;
  logic             hit;

  always_comb begin
    prescaled = (mode == MODE_RISE4) || (mode == MODE_RISE16);
    lim       = (mode == MODE_RISE4) ? LIM4 : LIM16;
    hit       = rise && prescaled && (cnt_q == lim);
    unique case (mode)
      MODE_FALL:   cap_ev = fall;
      MODE_RISE:   cap_ev = rise;
      MODE_RISE4,
      MODE_RISE16: cap_ev = hit;
      default:     cap_ev = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                  cnt_q <= '0;
    else if (mode_wr)            cnt_q <= '0;
    else if (rise && prescaled)  cnt_q <= hit ? '0 : cnt_q + 1'b1;
endmodule

// File: rtl/tcap_regs.sv
module tcap_regs
  import tcap_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              cap_ev,
  input  logic [TMR_W-1:0]  tval,
  output logic [BYTE_W-1:0] rdata,
  output logic [TMR_W-1:0]  cap_q,
  output cap_ctrl_t         ctrl_q,
  output logic              flag_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      ctrl_q <= '0;
      flag_q <= 1'b0;
    end else begin
      if (we) begin
        unique case (addr)
          A_CAP_LO: cap_q[BYTE_W-1:0]       <= wdata;
          A_CAP_HI: cap_q[TMR_W-1:BYTE_W]   <= wdata;
          A_CTRL:   ctrl_q                  <= cap_ctrl_t'(wdata[4:0]);
          A_FLAG:   flag_q                  <= wdata[0];
          default:  ;
        endcase
      end
      if (cap_ev) begin
        cap_q  <= tval;
        flag_q <= 1'b1;
      end
    end
  end

  always_comb begin
    unique case (addr)
      A_CAP_LO: rdata = cap_q[BYTE_W-1:0];
      A_CAP_HI: rdata = cap_q[TMR_W-1:BYTE_W];
      A_CTRL:   rdata = {3'b000, ctrl_q};
      default:  rdata = {7'b0, flag_q};
    endcase
  end
endmodule

// File: rtl/tcap_top.sv
module tcap_top
  import tcap_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int PRE_W       = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pin_i,
  input  logic              pin_oe_i,
  input  logic              pin_dout_i,
  input  logic [TMR_W-1:0]  tmr_a_i,
  input  logic [TMR_W-1:0]  tmr_b_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [BYTE_W-1:0] reg_wdata_i,
  output logic [BYTE_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  logic             pin_obs;
  logic             rise, fall;
  logic             cap_ev;
  logic             mode_wr;
  logic [TMR_W-1:0] tval;
  logic [TMR_W-1:0] cap_q;
  cap_ctrl_t        ctrl_q;
  logic             flag_q;

  assign pin_obs = pin_oe_i ? pin_dout_i : pin_i;
  assign mode_wr = reg_we_i && (reg_addr_i == A_CTRL);
  assign tval    = ctrl_q.tsel ? tmr_b_i : tmr_a_i;
  assign irq_o   = flag_q;

  tcap_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  (pin_obs),
    .rise (rise),
    .fall (fall)
  );

  tcap_event_sel #(.PRE_W(PRE_W)) u_evt (
    .clk    (clk),
    .rst_n  (rst_n),
    .rise   (rise),
    .fall   (fall),
    .mode   (ctrl_q.mode),
    .mode_wr(mode_wr),
    .cap_ev (cap_ev)
  );

  tcap_regs u_regs (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (reg_we_i),
    .addr  (reg_addr_i),
    .wdata (reg_wdata_i),
    .cap_ev(cap_ev),
    .tval  (tval),
    .rdata (reg_rdata_o),
    .cap_q (cap_q),
    .ctrl_q(ctrl_q),
    .flag_q(flag_q)
  );
endmodule

// File: rtl/tcap_chk.sv
module tcap_chk
  import tcap_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              reg_we_i,
  input logic [ADDR_W-1:0] reg_addr_i,
  input logic [BYTE_W-1:0] reg_wdata_i,
  input logic [TMR_W-1:0]  tmr_a_i,
  input logic [TMR_W-1:0]  tmr_b_i,
  input logic              irq_o,
  input logic              cap_ev,
  input logic [TMR_W-1:0]  cap_q,
  input cap_ctrl_t         ctrl_q
);
  logic clr_wr, cap_wr;
  assign clr_wr = reg_we_i && reg_addr_i == A_FLAG && !reg_wdata_i[0];
  assign cap_wr = reg_we_i && (reg_addr_i == A_CAP_LO || reg_addr_i == A_CAP_HI);

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o && !clr_wr |=> irq_o); // R8
  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |=> irq_o); // R11
  AST_TIMEBASE: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |=> cap_q == ($past(ctrl_q.tsel) ? $past(tmr_b_i) : $past(tmr_a_i))); // R7
  AST_OFF_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q.mode[3:2] != 2'b01 |-> !cap_ev); // R6
  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cap_ev && !cap_wr |=> $stable(cap_q)); // R9
endmodule

bind tcap_top tcap_chk u_chk (.*);

// File: tb/tb_tcap_top.sv
`timescale 1ns/1ps
module tb_tcap_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin_i = 1'b0, pin_oe_i = 1'b0, pin_dout_i = 1'b0;
  logic [15:0] tmr_a_i = '0, tmr_b_i = '0;
  logic        reg_we_i = 1'b0;
  logic [1:0]  reg_addr_i = '0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        irq_o;
  int          n_chk = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  tcap_top dut (.*);

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk);
    reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr_i = a;
    #1 d = reg_rdata_o;
  endtask

  task automatic rd_cap(output logic [15:0] v);
    logic [7:0] lo, hi;
    rd(2'd0, lo); rd(2'd1, hi);
    v = {hi, lo};
  endtask

  task automatic drive_pad(input logic v);
    @(negedge clk); pin_i = v;
    repeat (4) @(posedge clk);
  endtask

  task automatic drive_out(input logic v);
    @(negedge clk); pin_dout_i = v;
    repeat (4) @(posedge clk);
  endtask

  task automatic expect_cap(input string tag, input logic [15:0] exp);
    logic [15:0] v;
    rd_cap(v);
    check(v == exp, tag, v, exp);
  endtask

  task automatic expect_flag(input string tag, input logic exp);
    logic [7:0] f;
    rd(2'd3, f);
    check(f[0] == exp && irq_o == exp, tag, {irq_o, f[0]}, {exp, exp});
  endtask

  task automatic t_reset;
    logic [7:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      check(v == 8'h00, "R1 reset register", v, 0);
    end
    check(irq_o == 1'b0, "R1 reset irq", irq_o, 0);
  endtask

  task automatic t_regs;
    logic [7:0] v;
    wr(2'd0, 8'h34); wr(2'd1, 8'h12);
    expect_cap("R12 capture bytes", 16'h1234);
    wr(2'd2, 8'hFF); rd(2'd2, v);
    check(v == 8'h1F, "R12 control readback", v, 8'h1F);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_rise;
    wr(2'd2, 8'h05); wr(2'd3, 8'h00);
    tmr_a_i = 16'h1111;
    drive_pad(1'b1);
    expect_cap("R3 rising edge", 16'h1111);
    expect_flag("R3 flag on capture", 1'b1);
    tmr_a_i = 16'h2222;
    drive_pad(1'b0);
    expect_cap("R3 falling ignored", 16'h1111);
  endtask

  task automatic t_fall;
    wr(2'd2, 8'h04);
    tmr_a_i = 16'h3333;
    drive_pad(1'b1);
    expect_cap("R2 rising ignored", 16'h1111);
    drive_pad(1'b0);
    expect_cap("R2 falling edge", 16'h3333);
  endtask

  task automatic t_sel;
    wr(2'd2, 8'h15);
    tmr_a_i = 16'h0A0A; tmr_b_i = 16'hBEEF;
    drive_pad(1'b1);
    expect_cap("R7 timer B", 16'hBEEF);
    drive_pad(1'b0);
    wr(2'd2, 8'h05);
    tmr_a_i = 16'h4321;
    drive_pad(1'b1);
    expect_cap("R7 timer A", 16'h4321);
    drive_pad(1'b0);
  endtask

  task automatic t_prescale(input logic [7:0] code, input int n, input string tag);
    wr(2'd0, 8'h00); wr(2'd1, 8'h00);
    wr(2'd2, code); wr(2'd3, 8'h00);
    for (int i = 1; i <= n; i++) begin
      tmr_a_i = 16'h5000 + 16'(i);
      drive_pad(1'b1);
      drive_pad(1'b0);
      if (i == n - 1) begin
        expect_cap({tag, " no early capture"}, 16'h0000);
        expect_flag({tag, " flag before count"}, 1'b0);
      end
    end
    expect_cap({tag, " capture on last edge"}, 16'h5000 + 16'(n));
  endtask

  task automatic t_disabled;
    wr(2'd0, 8'hCD); wr(2'd1, 8'hAB);
    for (int k = 0; k < 2; k++) begin
      wr(2'd2, k == 0 ? 8'h00 : 8'h08); wr(2'd3, 8'h00);
      tmr_a_i = 16'h7777;
      drive_pad(1'b1); drive_pad(1'b0);
      expect_cap("R6 disabled no capture", 16'hABCD);
      expect_flag("R6 disabled no flag", 1'b0);
    end
  endtask

  task automatic t_sticky;
    wr(2'd2, 8'h05);
    tmr_a_i = 16'h0101;
    drive_pad(1'b1);
    repeat (10) @(posedge clk);
    expect_flag("R8 flag holds", 1'b1);
    wr(2'd3, 8'h01);
    expect_flag("R8 write one keeps", 1'b1);
    wr(2'd3, 8'h00);
    expect_flag("R8 host clear", 1'b0);
    drive_pad(1'b0);
  endtask

  task automatic t_overwrite;
    tmr_a_i = 16'h0AAA; drive_pad(1'b1); drive_pad(1'b0);
    tmr_a_i = 16'h0BBB; drive_pad(1'b1); drive_pad(1'b0);
    expect_cap("R9 overwrite unread", 16'h0BBB);
  endtask

  task automatic t_outpin;
    pin_oe_i = 1'b1;
    repeat (4) @(posedge clk);
    wr(2'd3, 8'h00);
    tmr_a_i = 16'h0C0C;
    drive_pad(1'b1); drive_pad(1'b0);
    expect_cap("R10 pad ignored", 16'h0BBB);
    drive_out(1'b1);
    expect_cap("R10 latch edge capture", 16'h0C0C);
    drive_out(1'b0);
    pin_oe_i = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  task automatic t_collide;
    wr(2'd3, 8'h00);
    tmr_a_i = 16'h0D0D;
    @(negedge clk); pin_i = 1'b1;
    @(negedge clk);
    @(negedge clk);
    reg_we_i = 1'b1; reg_addr_i = 2'd3; reg_wdata_i = 8'h00;
    @(negedge clk); reg_we_i = 1'b0;
    expect_flag("R11 capture beats clear", 1'b1);
    expect_cap("R11 captured value", 16'h0D0D);
    drive_pad(1'b0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_regs();
    t_rise();
    t_fall();
    t_sel();
    t_prescale(8'h06, 4, "R4");
    t_prescale(8'h07, 16, "R5");
    t_disabled();
    t_sticky();
    t_overwrite();
    t_outpin();
    t_collide();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule